// File: doc/BRIEF.md
# Timer slave mode controller

This block is a 16-bit up-counter whose clocking, starting and clearing are governed by one selected trigger. A 4-bit mode code picks the behaviour: plain counting on the internal clock, clear on a trigger, counting gated by the trigger level, start on a trigger, one count per trigger edge, or clear and start together. A 3-bit select code picks the trigger from four internal trigger lines, from a detector that pulses on both edges of an external input, or from the level of that external input after a polarity control.

Every trigger input passes through a two-flop synchroniser before edges are taken in the internal clock domain. A detected trigger rising edge therefore acts on the counter on the third rising clock edge after the input changes. A small run/halt state machine holds the counter enable. It has two states, `ST_HALT` and `ST_RUN`. Two transitions lead from `ST_HALT` to `ST_RUN`: *sw_start*, taken when the enable input is high, and *trig_start*, taken on a trigger rising edge in start or clear-and-start mode. One transition leads back: *sw_stop*, taken when the enable input is low and the mode is neither start nor clear-and-start. An output process turns the state, the mode and the trigger into a count tick and a clear.

Top module: `slave_tmr_ctrl`

## Requirements
- R1: While reset is asserted the counter reads 0, the update pulse is low, the trigger flag is low and the controller is halted.
- R2: In mode 4'b0000 with the enable input high, the counter advances by one every clock from the second clock after enable, and trigger edges never clear it.
- R3: When the counter equals the reload value and advances, it becomes 0 and the update output is high for exactly that one cycle.
- R4: In mode 4'b0100 a trigger rising edge clears the counter to 0 and raises the update output; both appear after the third clock edge following the input change.
- R5: In mode 4'b0101 the counter advances only while the selected trigger is high, and it holds its value (no clear) while the trigger is low.
- R6: In mode 4'b0110 a trigger rising edge starts a halted counter without clearing it, and a later falling trigger does not stop it.
- R7: In mode 4'b0111 the counter advances by exactly one per trigger rising edge and holds between edges.
- R8: In mode 4'b1000 a trigger rising edge clears the counter, raises the update output and starts the counter, all from the halted state.
- R9: Codes 4'b0001 to 4'b0011 and 4'b1001 to 4'b1111 behave exactly like mode 4'b0000.
- R10: Select 3'b000 to 3'b011 picks internal trigger line 0 to 3. Select 3'b110 and 3'b111 give no trigger.
- R11: Select 3'b100 produces one trigger rising edge on every transition of the external input, rising or falling.
- R12: Select 3'b101 uses the external input level XOR the polarity bit. With polarity 0 a rising external edge is active. With polarity 1 a falling external edge is active.
- R13: Every trigger rising edge, in any mode, sets a sticky trigger flag. A one-cycle clear strobe resets the flag. A set in the same cycle takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_en_i | input | 1 | Counter enable |
| mode_i | input | 4 | Slave mode code |
| tsel_i | input | 3 | Trigger source select |
| ext_pol_i | input | 1 | External input polarity, 1 inverts |
| itr_i | input | 4 | Internal trigger lines |
| ext_in_i | input | 1 | Filtered external input |
| arr_i | input | 16 | Reload value, last count before wrap |
| flag_clr_i | input | 1 | Write-one strobe clearing the trigger flag |
| cnt_o | output | 16 | Counter value |
| upd_o | output | 1 | Update event pulse |
| trig_flag_o | output | 1 | Sticky trigger flag |

## Verification
A table walks each select code with the addressed line raised and, in a second set of vectors, with only the other lines raised. This separates a correct source mux from one that picks a neighbouring line or listens on unused codes. Directed runs then apply each mode to the same trigger pulses. Pulses that clear the counter in one mode must be ignored in disabled and reserved modes. A level that gates counting must not clear the counter. A start must keep the value the counter held before. For the external input, only transitions in both directions set apart the both-edge detector from the polarity-controlled level path.

// File: rtl/slv_tmr_pkg.sv
package slv_tmr_pkg;

    localparam int MODE_W = 4;
    localparam int TSEL_W = 3;

    typedef enum logic [MODE_W-1:0] {
        MD_OFF    = 4'b0000,
        MD_RESET  = 4'b0100,
        MD_GATED  = 4'b0101,
        MD_TRIG   = 4'b0110,
        MD_EXTCLK = 4'b0111,
        MD_COMBO  = 4'b1000
    } mode_e;

    typedef enum logic {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } run_st_e;

    // Reserved codes fold onto the disabled mode
    function automatic mode_e decode_mode(input logic [MODE_W-1:0] code);
        case (code)
            4'b0100: return MD_RESET;
            4'b0101: return MD_GATED;
            4'b0110: return MD_TRIG;
            4'b0111: return MD_EXTCLK;
            4'b1000: return MD_COMBO;
            default: return MD_OFF;
        endcase
    endfunction

endpackage

// File: rtl/tsm_trig_front.sv
module tsm_trig_front
    import slv_tmr_pkg::*;
#(
    parameter int NUM_ITR     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_ITR-1:0] itr_i,
    input  logic               ext_i,
    input  logic               pol_i,
    input  logic [TSEL_W-1:0]  tsel_i,
    output logic               trg_lvl_o,
    output logic               trg_rise_o
);

    localparam int RAW_W = NUM_ITR + 1;
    localparam logic [TSEL_W-1:0] SEL_EDGE  = 3'd4;
    localparam logic [TSEL_W-1:0] SEL_LEVEL = 3'd5;

    logic [RAW_W-1:0]                  raw;
    logic [SYNC_STAGES-1:0][RAW_W-1:0] sync_q;
    logic [RAW_W-1:0]                  stable;
    logic                              ext_lvl;
    logic                              ext_q;
    logic                              ext_pulse;
    logic                              sel;
    logic                              trg_q;

    // Polarity is applied before the synchroniser so one chain serves all paths
    assign raw = {ext_i ^ pol_i, itr_i};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q[0] <= raw;
            for (int i = 1; i < SYNC_STAGES; i++) begin
                sync_q[i] <= sync_q[i-1];
            end
        end
    end

    assign stable    = sync_q[SYNC_STAGES-1];
    assign ext_lvl   = stable[NUM_ITR];
    assign ext_pulse = ext_lvl ^ ext_q;

    always_comb begin
        sel = 1'b0;
        for (int k = 0; k < NUM_ITR; k++) begin
            if (tsel_i == TSEL_W'(k)) sel = stable[k];
        end
        if (tsel_i == SEL_EDGE)  sel = ext_pulse;
        if (tsel_i == SEL_LEVEL) sel = ext_lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_q <= 1'b0;
            trg_q <= 1'b0;
        end else begin
            ext_q <= ext_lvl;
            trg_q <= sel;
        end
    end

    assign trg_lvl_o  = sel;
    assign trg_rise_o = sel & ~trg_q;

endmodule

// File: rtl/tsm_mode_fsm.sv
module tsm_mode_fsm
    import slv_tmr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  mode_e mode_i,
    input  logic  cnt_en_i,
    input  logic  trg_lvl_i,
    input  logic  trg_rise_i,
    output logic  tick_o,
    output logic  clear_o
);

    run_st_e state_q;
    run_st_e state_d;
    logic    start_mode;
    logic    clear_mode;

    assign start_mode = (mode_i == MD_TRIG)  || (mode_i == MD_COMBO);
    assign clear_mode = (mode_i == MD_RESET) || (mode_i == MD_COMBO);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    // Transitions: sw_start / trig_start into ST_RUN, sw_stop back to ST_HALT
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: if (cnt_en_i || (start_mode && trg_rise_i)) state_d = ST_RUN;
            ST_RUN:  if (!cnt_en_i && !start_mode)                state_d = ST_HALT;
        endcase
    end

    // Outputs
    always_comb begin
        tick_o  = 1'b0;
        clear_o = trg_rise_i && clear_mode;
        unique case (state_q)
            ST_HALT: tick_o = 1'b0;
            ST_RUN: begin
                case (mode_i)
                    MD_GATED:  tick_o = trg_lvl_i;
                    MD_EXTCLK: tick_o = trg_rise_i;
                    default:   tick_o = 1'b1;
                endcase
            end
        endcase
    end

endmodule

// File: rtl/tsm_counter.sv
module tsm_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             clear_i,
    input  logic [CNT_W-1:0] arr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             upd_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_o <= '0;
            upd_o <= 1'b0;
        end else begin
            upd_o <= 1'b0;
            if (clear_i) begin
                cnt_o <= '0;
                upd_o <= 1'b1;
            end else if (tick_i) begin
                if (cnt_o == arr_i) begin
                    cnt_o <= '0;
                    upd_o <= 1'b1;
                end else begin
                    cnt_o <= cnt_o + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/slave_tmr_ctrl.sv
module slave_tmr_ctrl
    import slv_tmr_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int NUM_ITR     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cnt_en_i,
    input  logic [MODE_W-1:0]  mode_i,
    input  logic [TSEL_W-1:0]  tsel_i,
    input  logic               ext_pol_i,
    input  logic [NUM_ITR-1:0] itr_i,
    input  logic               ext_in_i,
    input  logic [CNT_W-1:0]   arr_i,
    input  logic               flag_clr_i,
    output logic [CNT_W-1:0]   cnt_o,
    output logic               upd_o,
    output logic               trig_flag_o
);

    mode_e mode_dec;
    logic  trg_lvl;
    logic  trg_rise;
    logic  tick;
    logic  clear;

    assign mode_dec = decode_mode(mode_i);

    tsm_trig_front #(
        .NUM_ITR     (NUM_ITR),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_front (
        .clk        (clk),
        .rst_n      (rst_n),
        .itr_i      (itr_i),
        .ext_i      (ext_in_i),
        .pol_i      (ext_pol_i),
        .tsel_i     (tsel_i),
        .trg_lvl_o  (trg_lvl),
        .trg_rise_o (trg_rise)
    );

    tsm_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode_dec),
        .cnt_en_i   (cnt_en_i),
        .trg_lvl_i  (trg_lvl),
        .trg_rise_i (trg_rise),
        .tick_o     (tick),
        .clear_o    (clear)
    );

    tsm_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick),
        .clear_i (clear),
        .arr_i   (arr_i),
        .cnt_o   (cnt_o),
        .upd_o   (upd_o)
    );

    // Sticky trigger flag, set wins over clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          trig_flag_o <= 1'b0;
        else if (trg_rise)   trig_flag_o <= 1'b1;
        else if (flag_clr_i) trig_flag_o <= 1'b0;
    end

endmodule

// File: rtl/slave_tmr_checker.sv
module slave_tmr_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       mode_i,
    input logic             flag_clr_i,
    input logic [CNT_W-1:0] cnt_o,
    input logic             upd_o,
    input logic             trig_flag_o,
    input logic             trg_lvl,
    input logic             trg_rise
);

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (cnt_o == '0 && !upd_o && !trig_flag_o));

    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o != $past(cnt_o)) |-> (cnt_o == CNT_W'($past(cnt_o) + 1'b1) || cnt_o == '0));

    p_upd_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |-> (cnt_o == '0));

    p_gate_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 4'b0101 && !trg_lvl) |=> $stable(cnt_o));

    p_extclk_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 4'b0111 && !trg_rise) |=> $stable(cnt_o));

    p_flag_sticky_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_flag_o && !flag_clr_i) |=> trig_flag_o);

    p_flag_set_r13: assert property (@(posedge clk) disable iff (!rst_n)
        trg_rise |=> trig_flag_o);

endmodule

bind slave_tmr_ctrl slave_tmr_checker #(.CNT_W(CNT_W)) u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode_i),
    .flag_clr_i  (flag_clr_i),
    .cnt_o       (cnt_o),
    .upd_o       (upd_o),
    .trig_flag_o (trig_flag_o),
    .trg_lvl     (trg_lvl),
    .trg_rise    (trg_rise)
);

// File: tb/test_slave_tmr_ctrl.sv
module test_slave_tmr_ctrl;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [2:0] sel;
        logic [3:0] itr;
        logic       exp;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{3'd0, 4'b0001, 1'b1},
        '{3'd1, 4'b0010, 1'b1},
        '{3'd2, 4'b0100, 1'b1},
        '{3'd3, 4'b1000, 1'b1},
        '{3'd0, 4'b1110, 1'b0},
        '{3'd2, 4'b1011, 1'b0},
        '{3'd6, 4'b1111, 1'b0},
        '{3'd7, 4'b1111, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_en = 1'b0;
    logic [3:0]  mode = 4'b0000;
    logic [2:0]  tsel = 3'd0;
    logic        pol = 1'b0;
    logic [3:0]  itr = 4'b0000;
    logic        ext = 1'b0;
    logic [15:0] arr = 16'd1000;
    logic        flag_clr = 1'b0;
    logic [15:0] cnt;
    logic        upd;
    logic        flag;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    slave_tmr_ctrl i_slave_tmr_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cnt_en_i    (cnt_en),
        .mode_i      (mode),
        .tsel_i      (tsel),
        .ext_pol_i   (pol),
        .itr_i       (itr),
        .ext_in_i    (ext),
        .arr_i       (arr),
        .flag_clr_i  (flag_clr),
        .cnt_o       (cnt),
        .upd_o       (upd),
        .trig_flag_o (flag)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cnt_en = 1'b0; mode = 4'b0000; tsel = 3'd0; pol = 1'b0;
        itr = 4'b0000; ext = 1'b0; arr = 16'd1000; flag_clr = 1'b0;
        tick(2);
        rst_n = 1'b1;
    endtask

    // Count to 6 in disabled mode, then halt with the value held
    task automatic preload_six();
        mode = 4'b0000; cnt_en = 1'b1;
        tick(6);
        cnt_en = 1'b0;
        tick(3);
    endtask

    initial begin
        // R1 reset state
        tick(1);
        chk("R1 cnt", cnt, 0);
        chk("R1 upd", upd, 0);
        chk("R1 flag", flag, 0);
        rst_n = 1'b1;

        // R10 / R13 select table
        do_reset();
        for (int v = 0; v < 8; v++) begin
            itr = 4'b0000; tsel = VECS[v].sel;
            tick(3);
            flag_clr = 1'b1; tick(1); flag_clr = 1'b0;
            itr = VECS[v].itr;
            tick(4);
            chk("R10 select", flag, VECS[v].exp);
        end

        // R13 sticky flag and clear
        do_reset();
        itr = 4'b0001; tick(4);
        chk("R13 set", flag, 1);
        tick(5);
        chk("R13 sticky", flag, 1);
        flag_clr = 1'b1; tick(1); flag_clr = 1'b0;
        chk("R13 clear", flag, 0);

        // R2 free running, triggers ignored
        do_reset();
        cnt_en = 1'b1; tick(6);
        chk("R2 count", cnt, 5);
        itr = 4'b0001; tick(4);
        chk("R2 no clear", cnt, 9);

        // R3 wrap
        do_reset();
        arr = 16'd3; cnt_en = 1'b1;
        tick(4);
        chk("R3 at reload", cnt, 3);
        chk("R3 no upd yet", upd, 0);
        tick(1);
        chk("R3 wrap", cnt, 0);
        chk("R3 upd", upd, 1);
        tick(1);
        chk("R3 upd one cycle", upd, 0);
        chk("R3 after wrap", cnt, 1);

        // R4 reset mode
        do_reset();
        mode = 4'b0100; cnt_en = 1'b1;
        tick(10);
        chk("R4 running", cnt, 9);
        itr = 4'b0001; tick(2);
        chk("R4 latency", cnt, 11);
        tick(1);
        chk("R4 clear", cnt, 0);
        chk("R4 upd", upd, 1);
        tick(1);
        chk("R4 resume", cnt, 1);

        // R5 gated mode
        do_reset();
        mode = 4'b0101; tsel = 3'd1; cnt_en = 1'b1;
        tick(6);
        chk("R5 gate low", cnt, 0);
        itr = 4'b0010; tick(2);
        chk("R5 latency", cnt, 0);
        tick(4);
        chk("R5 gate high", cnt, 4);
        itr = 4'b0000; tick(2);
        chk("R5 drain", cnt, 6);
        tick(5);
        chk("R5 hold", cnt, 6);

        // R6 trigger mode
        do_reset();
        preload_six();
        chk("R6 halted", cnt, 6);
        mode = 4'b0110; tsel = 3'd2; itr = 4'b0100;
        tick(3);
        chk("R6 not cleared", cnt, 6);
        tick(1);
        chk("R6 started", cnt, 7);
        itr = 4'b0000; tick(5);
        chk("R6 keeps running", cnt, 12);

        // R7 external clock
        do_reset();
        mode = 4'b0111; tsel = 3'd3; cnt_en = 1'b1;
        tick(5);
        chk("R7 idle", cnt, 0);
        for (int p = 0; p < 3; p++) begin
            itr = 4'b1000; tick(3);
            itr = 4'b0000; tick(3);
        end
        chk("R7 edges", cnt, 3);
        tick(5);
        chk("R7 hold", cnt, 3);

        // R8 combined
        do_reset();
        preload_six();
        mode = 4'b1000; tsel = 3'd0; itr = 4'b0001;
        tick(3);
        chk("R8 clear", cnt, 0);
        chk("R8 upd", upd, 1);
        tick(1);
        chk("R8 started", cnt, 1);
        tick(2);
        chk("R8 running", cnt, 3);

        // R9 reserved codes
        do_reset();
        mode = 4'b0010; cnt_en = 1'b1;
        tick(6);
        chk("R9 count", cnt, 5);
        itr = 4'b0001; tick(4);
        chk("R9 no clear", cnt, 9);
        mode = 4'b1111; itr = 4'b0000; tick(2);
        chk("R9 high code", cnt, 11);

        // R11 both-edge detector
        do_reset();
        mode = 4'b0111; tsel = 3'd4; cnt_en = 1'b1;
        ext = 1'b1; tick(4);
        chk("R11 rise", cnt, 1);
        ext = 1'b0; tick(4);
        chk("R11 fall", cnt, 2);
        ext = 1'b1; tick(4);
        chk("R11 rise again", cnt, 3);

        // R12 polarity 0
        do_reset();
        mode = 4'b0111; tsel = 3'd5; cnt_en = 1'b1;
        ext = 1'b1; tick(4);
        chk("R12 pol0 rise", cnt, 1);
        ext = 1'b0; tick(4);
        chk("R12 pol0 fall", cnt, 1);

        // R12 polarity 1
        do_reset();
        mode = 4'b0111; tsel = 3'd5; cnt_en = 1'b1;
        pol = 1'b1; ext = 1'b1; tick(4);
        chk("R12 pol1 idle", cnt, 0);
        ext = 1'b0; tick(4);
        chk("R12 pol1 fall", cnt, 1);
        ext = 1'b1; tick(4);
        chk("R12 pol1 rise", cnt, 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule